// File: doc/BRIEF.md
# Cascaded Master Clock Prescaler

This block derives the internal master-clock rate of an audio converter from one fast external master clock. Three programmable divider stages sit in series, each with its own small set of ratios, so the overall division is the product of the three settings. Composite ratios such as /6 or /60 then become available, which lets audio rates (48 kHz, 44.1 kHz) and voice rates (8 kHz, 11.025 kHz) come from a single crystal. For example, /3 then /2 then /1 turns 12.288 MHz into 2.048 MHz for 8 kHz sampling. Likewise, /1 then /4 then /1 turns 11.2896 MHz into 2.8224 MHz for 11.025 kHz.

The design stays in the external clock domain and produces clock enables, not derived clocks. `imclk_en_o` is a one-cycle pulse at the internal master-clock rate, which is 256 times the sample rate. `fs_stb_o` is a one-cycle pulse on every 256th internal-clock pulse, which marks the sample rate. The ratio selects come from register fields. Any change to them restarts every divider counter synchronously, so no short or merged pulse reaches downstream logic. All pins are plain control or status signals: there is no data stream, so no valid/ready handshake is needed.

Top module: `mcp_top`

## Requirements
- R1: The first-stage select `pre1_sel_i` uses 2'b00 for divide by 1, 2'b01 for divide by 2 and 2'b10 for divide by 3.
- R2: The second-stage select `pre2_sel_i` uses 2'b00 for divide by 1, 2'b01 for divide by 2 and 2'b10 for divide by 4.
- R3: The third-stage select `pre3_sel_i` uses 2'b00 for divide by 1, 2'b01 for divide by 2 and 2'b10 for divide by 5.
- R4: With steady selects, `imclk_en_o` is high for exactly one clock in every N clocks, where N is the product of the three stage ratios. When N > 1 it is never high on two consecutive clocks.
- R5: Code 2'b11 in any stage select is reserved and acts as divide by 1.
- R6: `fs_stb_o` is high for one clock on every 256th `imclk_en_o` pulse and only together with it, so its period is 256·N clocks.
- R7: When any select differs at a rising edge from the value in effect, that edge restarts all counters. Both outputs are then low for the next N clocks. The first `imclk_en_o` pulse appears after edge N past the change, and the first `fs_stb_o` appears after edge 256·N past the change.
- R8: While `rst_ni` is low both outputs are low and the selects in effect are all 2'b00. After release with all selects at 2'b00, `imclk_en_o` is high from the first edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | External master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pre1_sel_i | input | 2 | First-stage ratio select (/1, /2, /3) |
| pre2_sel_i | input | 2 | Second-stage ratio select (/1, /2, /4) |
| pre3_sel_i | input | 2 | Third-stage ratio select (/1, /2, /5) |
| imclk_en_o | output | 1 | Internal master-clock enable pulse |
| fs_stb_o | output | 1 | Sample-rate strobe, every 256th enable pulse |

## Verification
The checker watches four rules on every clock:
- a sample strobe never appears without an enable pulse;
- a select change silences the enable on the following clock;
- steady pass-through gives an enable on every clock;
- no two enable pulses are adjacent when any stage divides.

Exact pulse spacing for each ratio, the composite products, the reserved code, and the 256·N strobe period can only be shown by the directed scenarios. The same holds for the exact first-pulse position after a change, because these depend on counting across long windows.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

  localparam int unsigned NSTAGE = 3;

  typedef logic [1:0] sel_t;

  typedef enum logic [1:0] {
    SEL_BYPASS = 2'b00,
    SEL_LOW    = 2'b01,
    SEL_HIGH   = 2'b10,
    SEL_RSVD   = 2'b11
  } sel_code_e;

  // Ratio for one stage: the reserved code and bypass both give 1.
  function automatic int unsigned pick_ratio(input sel_t code,
                                             input int unsigned lo,
                                             input int unsigned hi);
    case (sel_code_e'(code))
      SEL_LOW:  return lo;
      SEL_HIGH: return hi;
      default:  return 1;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/mcp_div_stage.sv
// One divider stage: forwards one enable for every RATIO input enables.
module mcp_div_stage #(
  parameter int unsigned RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [RW-1:0] ratio_i,
  output logic          en_o
);

  logic [RW-1:0] cnt_q;
  logic          wrap;

  // A ratio of 1 keeps the count at zero, so every enable passes.
  assign wrap = (cnt_q == ratio_i - RW'(1));
  assign en_o = en_i & wrap;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (wrap) cnt_q <= '0;
      else      cnt_q <= cnt_q + RW'(1);
    end
  end

endmodule

// File: rtl/mcp_sel_track.sv
// Holds the selects in effect and flags a change for a synchronous restart.
module mcp_sel_track #(
  parameter int unsigned SW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  output logic [SW-1:0] sel_q_o,
  output logic          clr_o
);

  logic [SW-1:0] sel_q;

  assign clr_o   = (sel_i != sel_q);
  assign sel_q_o = sel_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_i;
  end

endmodule

// File: rtl/mcp_fs_count.sv
// Counts internal-clock enables and marks the last one of each frame.
module mcp_fs_count #(
  parameter int unsigned FS_DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);

  localparam int unsigned CW = $clog2(FS_DIV);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(FS_DIV - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (last_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/mcp_top.sv
module mcp_top #(
  parameter int unsigned S1_LO  = 2,
  parameter int unsigned S1_HI  = 3,
  parameter int unsigned S2_LO  = 2,
  parameter int unsigned S2_HI  = 4,
  parameter int unsigned S3_LO  = 2,
  parameter int unsigned S3_HI  = 5,
  parameter int unsigned FS_DIV = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pre1_sel_i,
  input  logic [1:0] pre2_sel_i,
  input  logic [1:0] pre3_sel_i,
  output logic       imclk_en_o,
  output logic       fs_stb_o
);
  import mcp_pkg::*;

  localparam int unsigned SW   = 2 * NSTAGE;
  localparam int unsigned MAXR = max3(max3(S1_LO, S1_HI, 1),
                                      max3(S2_LO, S2_HI, 1),
                                      max3(S3_LO, S3_HI, 1));
  localparam int unsigned RW   = $clog2(MAXR + 1);
  localparam int unsigned LO_SET [NSTAGE] = '{S1_LO, S2_LO, S3_LO};
  localparam int unsigned HI_SET [NSTAGE] = '{S1_HI, S2_HI, S3_HI};

  logic [SW-1:0]     sel_in;
  logic [SW-1:0]     sel_eff;
  logic              clr;
  logic [NSTAGE:0]   en_chain;
  logic              fs_last;
  logic              imclk_q;
  logic              fs_q;

  assign sel_in = {pre3_sel_i, pre2_sel_i, pre1_sel_i};

  mcp_sel_track #(.SW(SW)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_in),
    .sel_q_o(sel_eff),
    .clr_o  (clr)
  );

  assign en_chain[0] = 1'b1;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    logic [RW-1:0] ratio;

    always_comb begin
      ratio = RW'(pick_ratio(sel_eff[2*s +: 2], LO_SET[s], HI_SET[s]));
    end

    mcp_div_stage #(.RW(RW)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (en_chain[s]),
      .ratio_i(ratio),
      .en_o   (en_chain[s+1])
    );
  end

  mcp_fs_count #(.FS_DIV(FS_DIV)) u_fs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .en_i  (en_chain[NSTAGE]),
    .last_o(fs_last)
  );

  // Registered outputs; a restart cycle emits nothing.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      imclk_q <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      imclk_q <= en_chain[NSTAGE] & ~clr;
      fs_q    <= en_chain[NSTAGE] & ~clr & fs_last;
    end
  end

  assign imclk_en_o = imclk_q;
  assign fs_stb_o   = fs_q;

endmodule

// File: rtl/mcp_top_chk.sv
module mcp_top_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] pre1_sel_i,
  input logic [1:0] pre2_sel_i,
  input logic [1:0] pre3_sel_i,
  input logic       imclk_en_o,
  input logic       fs_stb_o
);

  logic [5:0] sel;
  logic       divides;
  logic [1:0] age_q;

  assign sel = {pre3_sel_i, pre2_sel_i, pre1_sel_i};

  // Codes 01 and 10 are the only ones that divide (ratio above 1).
  assign divides = (pre1_sel_i == 2'b01) || (pre1_sel_i == 2'b10) ||
                   (pre2_sel_i == 2'b01) || (pre2_sel_i == 2'b10) ||
                   (pre3_sel_i == 2'b01) || (pre3_sel_i == 2'b10);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_strobe_on_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_stb_o |-> imclk_en_o);

  assert_change_silences_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && sel != $past(sel)) |=> !imclk_en_o);

  assert_bypass_every_clock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && sel == 6'd0 && $past(sel) == 6'd0 && $past(sel, 2) == 6'd0)
      |-> imclk_en_o);

  assert_no_adjacent_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imclk_en_o && divides) |=> !imclk_en_o);

endmodule

bind mcp_top mcp_top_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pre1_sel_i(pre1_sel_i),
  .pre2_sel_i(pre2_sel_i),
  .pre3_sel_i(pre3_sel_i),
  .imclk_en_o(imclk_en_o),
  .fs_stb_o  (fs_stb_o)
);

// File: tb/mcp_top_tb_top.sv
`timescale 1ns/1ps
module mcp_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] s1 = 2'b00, s2 = 2'b00, s3 = 2'b00;
  logic       imclk_en, fs_stb;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  mcp_top dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pre1_sel_i(s1),
    .pre2_sel_i(s2),
    .pre3_sel_i(s3),
    .imclk_en_o(imclk_en),
    .fs_stb_o  (fs_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Change the selects, then expect pulses exactly at samples n+1 and 2n+1.
  task automatic run_ratio(input logic [1:0] a, input logic [1:0] b,
                           input logic [1:0] c, input int n, input string req);
    int bad_at = 0;
    int act = 0;
    int exp = 0;
    @(negedge clk); s1 = a; s2 = b; s3 = c;
    for (int i = 1; i <= 2*n + 1; i++) begin
      @(posedge clk); @(negedge clk);
      if (bad_at == 0) begin
        exp = ((i == n + 1) || (i == 2*n + 1)) ? 1 : 0;
        if (imclk_en !== exp[0] || fs_stb !== 1'b0) begin
          bad_at = i; act = imclk_en; 
        end
      end
    end
    check(bad_at == 0, req, act, exp);
    if (bad_at != 0) $display("  at sample %0d of ratio %0d", bad_at, n);
  endtask

  // Sample strobe: first after 256*n edges past the change, then every 256*n.
  task automatic run_fs(input logic [1:0] a, input logic [1:0] b,
                        input logic [1:0] c, input int n, input string req);
    int per = 256 * n;
    int hits = 0;
    int bad = 0;
    @(negedge clk); s1 = a; s2 = b; s3 = c;
    for (int i = 1; i <= 2*per + 1; i++) begin
      @(posedge clk); @(negedge clk);
      if (fs_stb === 1'b1) begin
        hits++;
        if (!((i == per + 1) || (i == 2*per + 1)) || imclk_en !== 1'b1) bad++;
      end
    end
    check(bad == 0 && hits == 2, req, hits, 2);
  endtask

  task automatic run_reset(input string req);
    int seen = 0;
    @(negedge clk); rst_n = 1'b0; s1 = 2'b00; s2 = 2'b00; s3 = 2'b00;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      if (imclk_en !== 1'b0 || fs_stb !== 1'b0) seen++;
    end
    check(seen == 0, req, seen, 0);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      if (imclk_en === 1'b1) seen++;
    end
    check(seen == 5, req, seen, 5);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R8: reset state and bypass after release
    run_reset("R8");
    // R1: first stage ratios
    run_ratio(2'b01, 2'b00, 2'b00, 2, "R1");
    run_ratio(2'b10, 2'b00, 2'b00, 3, "R1");
    // R2: second stage ratios
    run_ratio(2'b00, 2'b01, 2'b00, 2, "R2");
    run_ratio(2'b00, 2'b10, 2'b00, 4, "R2");
    // R3: third stage ratios
    run_ratio(2'b00, 2'b00, 2'b01, 2, "R3");
    run_ratio(2'b00, 2'b00, 2'b10, 5, "R3");
    // R4: composite products
    run_ratio(2'b10, 2'b01, 2'b00, 6, "R4");
    run_ratio(2'b10, 2'b10, 2'b10, 60, "R4");
    run_ratio(2'b01, 2'b10, 2'b01, 16, "R4");
    // R5: reserved codes act as bypass
    run_ratio(2'b11, 2'b11, 2'b11, 1, "R5");
    run_ratio(2'b10, 2'b11, 2'b01, 6, "R5");
    // R7: back-to-back change restarts counting from the new edge
    run_ratio(2'b00, 2'b00, 2'b00, 1, "R7");
    run_ratio(2'b01, 2'b01, 2'b00, 4, "R7");
    // R6: sample strobe period
    run_fs(2'b11, 2'b00, 2'b00, 1, "R6");
    run_fs(2'b10, 2'b01, 2'b00, 6, "R6");
    // R8: reset in the middle of a divided run
    run_reset("R8");
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule